// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This block sits between a simple register port and twenty peripheral consumers. For each consumer it drives one clock-enable line, meant for a glitch-free gating cell outside the block, and one reset line. The consumers fall into three groups: an interconnect group, a fast bridge group and a slow bridge group. Software turns a clock on by writing a consumer's code to an enable strobe register, and turns it off by writing the same code to a separate disable strobe register. It reads back which clocks run through one status register per group. It holds or releases each consumer's reset through one read/write reset register per group.

Each consumer has a fixed place on the output vectors. Group 0: 0 cpu (hw, reset/status bit 3), 1 dma (hw, 4/4), 2 nand (5 is emif; nand 6/6), 3 graphics (hw, 8/8), 4 shared memory (9/9), 5 local bus bridge (hw, 10/10), 6 interrupt controller (reset-only, 12/12), 7 emif (5/5). Group 1: 8 fast bridge (hw, 0/0), 9 i2c0 (1/1), 10 i2c1 (2/2), 11 mmc (5/5), 12 spi (6/6). Group 2: 13 slow bridge (hw, 0/0), 14 uart0 (1/1), 15 gpio (4/4), 16 keypad (reset 5, status 6), 17 rtc (hw, reset 6, no status bit), 18 app timer (7/7), 19 access timer (8/8). The register port has 3-bit addresses: 0 is the enable strobe, 1 the disable strobe, 2/3/4 the status of groups 0/1/2, and 5/6/7 the reset registers of groups 0/1/2. A write takes effect at the clock edge where `reg_we` is high. A read is combinational on `reg_addr`.

Top module: `clkrst_ctrl`

## Requirements
- R1: A well-formed code is 16 bits with bit 15 = 0, bits 14:13 = group (0, 1 or 2) and bits 12:0 one-hot at the consumer's status bit position. Writing it to address 0 sets that consumer's `clk_en_o` bit from the next cycle on.
- R2: Writing the same code to address 1 clears that consumer's `clk_en_o` bit from the next cycle on.
- R3: A strobe write changes no `clk_en_o` bit other than the one addressed.
- R4: Addresses 0 and 1 always read as 0x0000.
- R5: Status registers (addresses 2, 3, 4) show a 1 at each consumer's status bit while its clock is enabled. Bits that belong to no consumer read 0.
- R6: Reset registers (addresses 5, 6, 7) are 16-bit read/write. A 1 at a consumer's reset bit drives its `blk_rst_o` high, and a 0 releases it.
- R7: After `rst_n` low, all reset registers read 0xFFFF, every `blk_rst_o` is 1 and every software-gated clock is off.
- R8: A consumer with no status bit (rtc) has its clock always enabled.
- R9: A strobe value that is not well-formed, including 0xFFFF, changes nothing.
- R10: Hardware-controlled consumers and the reset-only interrupt controller keep `clk_en_o` at 1 and ignore both strobes. Their reset bits stay under software control.
- R11: Reset and status positions are independent. The keypad is released by slow reset bit 5, while it shows in slow status bit 6, and bit 5 does not touch gpio (bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and state clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on address |
| clk_en_o | output | 20 | Per-consumer clock enable |
| blk_rst_o | output | 20 | Per-consumer reset, active high |

## Verification
The strobes are tried with codes for consumers in two different groups. This shows whether the group field and the one-hot position are both decoded, and whether an enable in one group survives a disable in another. Malformed values are used next: all ones, two bits set, group 3 and bit 15 set. Each of them must leave the enable vector unchanged. Strobes aimed at hardware-controlled and reset-only consumers tell ignoring apart from gating. Separate reset and status positions for the keypad tell a design that reuses one index from one that keeps both.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  localparam int REG_W  = 16;
  localparam int N_GRP  = 3;
  localparam int N_CONS = 20;
  localparam int POS_W  = 13;
  localparam int ADDR_W = 3;
  localparam int GRP_LSB = POS_W;
  localparam logic [ADDR_W-1:0] A_EN_STB  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIS_STB = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RST0    = 3'd5;

  typedef struct packed {
    logic [1:0] grp;
    logic [3:0] rst_bit;
    logic [3:0] st_bit;
    logic       has_st;
    logic       sw_gate;
  } cons_t;

  function automatic cons_t mk(input int g, input int rb, input int sb, input bit hs, input bit sw);
    cons_t c;
    c.grp = 2'(g); c.rst_bit = 4'(rb); c.st_bit = 4'(sb);
    c.has_st = hs; c.sw_gate = sw;
    return c;
  endfunction

  function automatic cons_t cons_attr(input int i);
    case (i)
      0:  return mk(0, 3, 3, 1, 0);
      1:  return mk(0, 4, 4, 1, 0);
      2:  return mk(0, 6, 6, 1, 1);
      3:  return mk(0, 8, 8, 1, 0);
      4:  return mk(0, 9, 9, 1, 1);
      5:  return mk(0, 10, 10, 1, 0);
      6:  return mk(0, 12, 12, 1, 0);
      7:  return mk(0, 5, 5, 1, 1);
      8:  return mk(1, 0, 0, 1, 0);
      9:  return mk(1, 1, 1, 1, 1);
      10: return mk(1, 2, 2, 1, 1);
      11: return mk(1, 5, 5, 1, 1);
      12: return mk(1, 6, 6, 1, 1);
      13: return mk(2, 0, 0, 1, 0);
      14: return mk(2, 1, 1, 1, 1);
      15: return mk(2, 4, 4, 1, 1);
      16: return mk(2, 5, 6, 1, 1);
      17: return mk(2, 6, 0, 0, 0);
      18: return mk(2, 7, 7, 1, 1);
      default: return mk(2, 8, 8, 1, 1);
    endcase
  endfunction

  // Well-formed strobe code: top bit clear, group below 3, one-hot position
  function automatic logic code_ok(input logic [REG_W-1:0] c);
    return !c[REG_W-1] && (c[GRP_LSB+1:GRP_LSB] != 2'd3) && $onehot(c[POS_W-1:0]);
  endfunction

  function automatic logic [N_CONS-1:0] fixed_on_mask();
    logic [N_CONS-1:0] m;
    m = '0;
    for (int i = 0; i < N_CONS; i++) m[i] = !cons_attr(i).sw_gate;
    return m;
  endfunction
endpackage

// File: rtl/clkrst_strobe_dec.sv
module clkrst_strobe_dec
  import clkrst_pkg::*;
(
  input  logic [REG_W-1:0]  code,
  output logic [N_CONS-1:0] hit
);
  logic ok;
  assign ok = code_ok(code);

  for (genvar i = 0; i < N_CONS; i++) begin : g_hit
    localparam cons_t C = cons_attr(i);
    if (C.sw_gate && C.has_st) begin : g_sw
      assign hit[i] = ok && (code[GRP_LSB+1:GRP_LSB] == C.grp) && code[C.st_bit];
    end else begin : g_fixed
      assign hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/clkrst_gate_bank.sv
module clkrst_gate_bank
  import clkrst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CONS-1:0] set_vec,
  input  logic [N_CONS-1:0] clr_vec,
  output logic [N_CONS-1:0] en
);
  for (genvar i = 0; i < N_CONS; i++) begin : g_en
    localparam cons_t C = cons_attr(i);
    if (C.sw_gate) begin : g_sw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
        else if (clr_vec[i]) q <= 1'b0;
      end
      assign en[i] = q;
    end else begin : g_fixed
      assign en[i] = 1'b1;
    end
  end
endmodule

// File: rtl/clkrst_regfile.sv
module clkrst_regfile
  import clkrst_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  input  logic [N_CONS-1:0]      clk_en,
  output logic [REG_W-1:0]       rdata,
  output logic [N_GRP-1:0][REG_W-1:0] rst_q
);
  logic [N_GRP-1:0][REG_W-1:0] stat;
  logic [1:0] rst_idx, stat_idx;
  logic       rst_sel;

  assign rst_idx  = 2'(addr - A_RST0);
  assign stat_idx = 2'(addr - A_STAT0);
  assign rst_sel  = addr >= A_RST0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rst_q <= '1;
    else if (we && rst_sel)  rst_q[rst_idx] <= wdata;
  end

  always_comb begin
    stat = '0;
    for (int i = 0; i < N_CONS; i++)
      if (cons_attr(i).has_st)
        stat[cons_attr(i).grp][cons_attr(i).st_bit] = stat[cons_attr(i).grp][cons_attr(i).st_bit] | clk_en[i];
  end

  always_comb begin
    if (rst_sel)             rdata = rst_q[rst_idx];
    else if (addr >= A_STAT0) rdata = stat[stat_idx];
    else                     rdata = '0;
  end
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
  import clkrst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [N_CONS-1:0]     clk_en_o,
  output logic [N_CONS-1:0]     blk_rst_o
);
  logic [N_CONS-1:0] dec_hit, set_vec, clr_vec;
  logic [N_GRP-1:0][REG_W-1:0] rst_q;

  clkrst_strobe_dec u_dec (.code(reg_wdata), .hit(dec_hit));

  assign set_vec = (reg_we && reg_addr == A_EN_STB)  ? dec_hit : '0;
  assign clr_vec = (reg_we && reg_addr == A_DIS_STB) ? dec_hit : '0;

  clkrst_gate_bank u_gate (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .en(clk_en_o)
  );

  clkrst_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .clk_en(clk_en_o), .rdata(reg_rdata), .rst_q(rst_q)
  );

  for (genvar i = 0; i < N_CONS; i++) begin : g_rst
    localparam cons_t C = cons_attr(i);
    assign blk_rst_o[i] = rst_q[C.grp][C.rst_bit];
  end
endmodule

// File: rtl/clkrst_ctrl_chk.sv
module clkrst_ctrl_chk
  import clkrst_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [REG_W-1:0]      reg_rdata,
  input logic [N_CONS-1:0]     clk_en_o,
  input logic [N_CONS-1:0]     set_vec,
  input logic [N_CONS-1:0]     clr_vec
);
  localparam logic [N_CONS-1:0] FIXED = fixed_on_mask();

  p_set_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((clk_en_o & $past(set_vec)) == $past(set_vec)));

  p_clr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((clk_en_o & $past(clr_vec)) == '0));

  p_others_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (((clk_en_o ^ $past(clk_en_o)) & ~($past(set_vec) | $past(clr_vec))) == '0));

  p_strobe_rd0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_EN_STB || reg_addr == A_DIS_STB) |-> (reg_rdata == '0));

  p_malformed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr <= A_DIS_STB && !code_ok(reg_wdata)) |=> $stable(clk_en_o));

  p_fixed_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ((clk_en_o & FIXED) == FIXED));
endmodule

bind clkrst_ctrl clkrst_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o),
  .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/tb_clkrst_ctrl.sv
module tb_clkrst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [19:0] clk_en_o, blk_rst_o;

  int n_run = 0;
  int n_fail = 0;

  // Consumers whose clock never gates: cpu, dma, graphics, bridge, intc, fast bridge, slow bridge, rtc
  localparam logic [19:0] FIXED_EXP = 20'h2216B;

  clkrst_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o), .blk_rst_o(blk_rst_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] code(input int grp, input int pos);
    return 16'((grp << 13) | (1 << pos));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); check("R7 reset reg", d, 16'hFFFF);
    end
    check("R7 blk_rst_o", blk_rst_o, 20'hFFFFF);
    check("R7 clk_en_o", clk_en_o, FIXED_EXP);
    rd(3'd2, d); check("R5 stat g0", d, 16'h1518);
    rd(3'd3, d); check("R5 stat g1", d, 16'h0001);
    rd(3'd4, d); check("R5 stat g2", d, 16'h0001);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr(3'd0, code(0, 6));
    check("R1 nand on", clk_en_o, FIXED_EXP | 20'h4);
    rd(3'd2, d); check("R5 stat g0 nand", d, 16'h1558);
    wr(3'd0, code(1, 2));
    check("R1 R3 i2c1 on", clk_en_o, FIXED_EXP | 20'h404);
    rd(3'd3, d); check("R5 stat g1 i2c1", d, 16'h0005);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    wr(3'd1, code(0, 6));
    check("R2 R3 nand off", clk_en_o, FIXED_EXP | 20'h400);
    rd(3'd2, d); check("R5 stat g0 after off", d, 16'h1518);
  endtask

  task automatic t_strobe_read();
    logic [15:0] d;
    rd(3'd0, d); check("R4 en strobe read", d, 16'h0000);
    rd(3'd1, d); check("R4 dis strobe read", d, 16'h0000);
  endtask

  task automatic t_malformed();
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    check("R9 all ones", clk_en_o, FIXED_EXP | 20'h400);
    wr(3'd0, 16'h0041);
    wr(3'd1, 16'h2006);
    wr(3'd0, 16'h6001);
    wr(3'd0, 16'h8040);
    check("R9 malformed codes", clk_en_o, FIXED_EXP | 20'h400);
  endtask

  task automatic t_fixed();
    logic [15:0] d;
    wr(3'd1, code(0, 3));
    wr(3'd1, code(0, 12));
    wr(3'd1, code(1, 0));
    wr(3'd1, code(2, 0));
    check("R10 fixed clocks stay on", clk_en_o, FIXED_EXP | 20'h400);
    check("R8 rtc always on", 32'(clk_en_o[17]), 32'd1);
    rd(3'd2, d); check("R10 stat g0 fixed", d, 16'h1518);
  endtask

  task automatic t_keypad();
    logic [15:0] d;
    wr(3'd7, 16'hFFDF);
    rd(3'd7, d); check("R6 slow reset readback", d, 16'hFFDF);
    check("R11 keypad released", 32'(blk_rst_o[16]), 32'd0);
    check("R11 gpio held", 32'(blk_rst_o[15]), 32'd1);
    wr(3'd0, code(2, 6));
    check("R11 keypad clock", clk_en_o, FIXED_EXP | 20'h10400);
    rd(3'd4, d); check("R11 stat g2 keypad", d, 16'h0041);
  endtask

  task automatic t_reset_rw();
    logic [15:0] d;
    wr(3'd5, 16'hEFF7);
    rd(3'd5, d); check("R6 g0 reset readback", d, 16'hEFF7);
    check("R6 R10 blk_rst_o", blk_rst_o, 20'hEFFBE);
    wr(3'd6, 16'h1234);
    rd(3'd6, d); check("R6 g1 reset readback", d, 16'h1234);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_strobe_read();
    t_malformed();
    t_fixed();
    t_keypad();
    t_reset_rw();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule